// File: doc/BRIEF.md
# Read-While-Write Fetch Guard

This block sits between the CPU fetch path and the flash array of a part that can reprogram its own flash. The flash is split at a page boundary that is fixed by a parameter. Pages below the boundary form the rewritable region, which can be erased or written while code keeps running. Pages at or above the boundary form the protected region, and the boot region sits at the top of it. The command controller tells the guard when an erase or page write starts, which page it targets, and when it finishes. For every fetch, the guard decides in the same cycle whether the fetch may go to the array.

A running operation on a rewritable page blocks fetches from the rewritable region. Fetches from the protected region are still served. A blocked fetch gets a fixed filler word and raises a violation flag. A running operation on a protected page halts the whole CPU instead. The section-busy bit, which software can read, stays set after a rewritable operation ends. It clears only when software writes the read-enable command. A programmed boot lock makes the guard refuse any operation aimed at the boot region.

The control state machine has four states. IDLE means no operation is tracked. RWW_RUN means a rewritable-region operation is in progress. RWW_HOLD means that operation is finished but reads are not yet re-enabled. NRWW_RUN means a protected-region operation is in progress and the CPU is halted. The transitions are:
- IDLE→RWW_RUN on an accepted start to a page below the boundary.
- IDLE→NRWW_RUN on an accepted start to a page at or above the boundary.
- RWW_RUN→RWW_HOLD on completion.
- RWW_HOLD→IDLE on read-enable.
- NRWW_RUN→IDLE on completion.

Every other case holds the current state.

Top module: `rwwg_top`

## Requirements
- R1: While the state is RWW_RUN or RWW_HOLD, a valid fetch to a page below RWW_PAGES is blocked, meaning fetch_grant=0, fetch_rdata=FILL_WORD and access_violation=1. A valid fetch to a page at or above RWW_PAGES is granted, and fetch_rdata equals flash_rdata. The page is fetch_addr shifted right by WORD_BITS.
- R2: An accepted start to a page at or above RWW_PAGES raises cpu_halt from the next cycle. cpu_halt stays high through the cycle in which op_done is high and is low in the cycle after. While cpu_halt is high, every valid fetch is blocked.
- R3: sect_busy is 1 from the cycle after an accepted start to a page below RWW_PAGES.
- R4: After op_done ends a rewritable operation, sect_busy stays 1 and fetches stay blocked until reread_en is high at a clock edge. From the next cycle, sect_busy is 0 and fetches to rewritable pages are granted.
- R5: reread_en has no effect while an operation is running, including in the cycle where op_done is also high. sect_busy stays 1 afterwards.
- R6: When boot_lock=1 and op_page is at or above BOOT_PAGE, op_start is refused. op_reject=1 in that cycle, and no halt or busy state follows.
- R7: op_start outside IDLE is refused. op_reject=1 in that cycle, and the state is unchanged.
- R8: After reset and in IDLE, cpu_halt=0 and sect_busy=0, and every valid fetch is granted with the flash data.
- R9: When fetch_valid=0, fetch_grant=0, access_violation=0 and fetch_rdata=FILL_WORD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch is requested this cycle |
| fetch_addr | input | ADDR_W | Fetch word address |
| flash_rdata | input | DATA_W | Word read from the flash array |
| op_start | input | 1 | Controller starts an erase or page write |
| op_page | input | PAGE_W | Target page of the starting operation |
| op_done | input | 1 | Controller finishes the running operation |
| reread_en | input | 1 | Software writes the read-enable command bit |
| boot_lock | input | 1 | Boot protection lock is programmed |
| fetch_grant | output | 1 | The fetch may proceed |
| fetch_rdata | output | DATA_W | Flash word, or the filler word when not granted |
| access_violation | output | 1 | A valid fetch was blocked |
| cpu_halt | output | 1 | CPU halt request |
| sect_busy | output | 1 | Rewritable section blocked, readable by software |
| op_reject | output | 1 | This cycle's start request is refused |

## Verification
Completion and the read-enable command can fall in the same clock edge. The bench provokes this by raising op_done and reread_en together during a rewritable operation. The correct outcome is that completion wins and the read-enable is dropped, so sect_busy stays 1 and fetches from rewritable pages stay blocked until a second read-enable. A start request that collides with a running operation is also provoked. It must be refused in that cycle without disturbing the state.

// File: rtl/rwwg_pkg.sv
package rwwg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RWW_RUN  = 2'd1,
        ST_RWW_HOLD = 2'd2,
        ST_NRWW_RUN = 2'd3
    } guard_state_e;

    typedef struct packed {
        logic in_rww;
        logic in_boot;
    } page_class_t;

endpackage

// File: rtl/rwwg_page_class.sv
module rwwg_page_class
    import rwwg_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int RWW_PAGES = 224,
    parameter int BOOT_PAGE = 240
) (
    input  logic [PAGE_W-1:0] page,
    output page_class_t       cls
);
    localparam logic [PAGE_W:0] RWW_LIM  = (PAGE_W+1)'(RWW_PAGES);
    localparam logic [PAGE_W:0] BOOT_LIM = (PAGE_W+1)'(BOOT_PAGE);

    always_comb begin
        cls.in_rww  = ({1'b0, page} < RWW_LIM);
        cls.in_boot = ({1'b0, page} >= BOOT_LIM);
    end
endmodule

// File: rtl/rwwg_ctrl.sv
module rwwg_ctrl
    import rwwg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_start,
    input  page_class_t op_cls,
    input  logic        op_done,
    input  logic        reread_en,
    input  logic        boot_lock,
    output logic        rww_blocked,
    output logic        halt,
    output logic        reject
);
    guard_state_e state_q, state_d;
    logic         refuse;

    always_comb begin
        refuse = op_start && ((state_q != ST_IDLE) || (boot_lock && op_cls.in_boot));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_start && !refuse)
                    state_d = op_cls.in_rww ? ST_RWW_RUN : ST_NRWW_RUN;
            end
            ST_RWW_RUN: begin
                if (op_done)
                    state_d = ST_RWW_HOLD;
            end
            ST_RWW_HOLD: begin
                if (reread_en)
                    state_d = ST_IDLE;
            end
            ST_NRWW_RUN: begin
                if (op_done)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        rww_blocked = 1'b0;
        halt        = 1'b0;
        reject      = refuse;
        unique case (state_q)
            ST_IDLE:     ;
            ST_RWW_RUN:  rww_blocked = 1'b1;
            ST_RWW_HOLD: rww_blocked = 1'b1;
            ST_NRWW_RUN: halt        = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/rwwg_fetch_gate.sv
module rwwg_fetch_gate
    import rwwg_pkg::*;
#(
    parameter int              DATA_W    = 16,
    parameter logic [DATA_W-1:0] FILL_WORD = '1
) (
    input  logic              fetch_valid,
    input  page_class_t       fetch_cls,
    input  logic [DATA_W-1:0] flash_rdata,
    input  logic              rww_blocked,
    input  logic              halt,
    output logic              grant,
    output logic [DATA_W-1:0] rdata,
    output logic              violation
);
    logic allowed;

    always_comb begin
        allowed   = !halt && !(rww_blocked && fetch_cls.in_rww);
        grant     = fetch_valid && allowed;
        violation = fetch_valid && !allowed;
        rdata     = grant ? flash_rdata : FILL_WORD;
    end
endmodule

// File: rtl/rwwg_top.sv
module rwwg_top
    import rwwg_pkg::*;
#(
    parameter int                ADDR_W    = 14,
    parameter int                WORD_BITS = 6,
    parameter int                DATA_W    = 16,
    parameter int                RWW_PAGES = 224,
    parameter int                BOOT_PAGE = 240,
    parameter logic [DATA_W-1:0] FILL_WORD = 16'hFFFF,
    localparam int               PAGE_W    = ADDR_W - WORD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] flash_rdata,
    input  logic              op_start,
    input  logic [PAGE_W-1:0] op_page,
    input  logic              op_done,
    input  logic              reread_en,
    input  logic              boot_lock,
    output logic              fetch_grant,
    output logic [DATA_W-1:0] fetch_rdata,
    output logic              access_violation,
    output logic              cpu_halt,
    output logic              sect_busy,
    output logic              op_reject
);
    page_class_t fetch_cls, op_cls;
    logic        rww_blocked, halt;

    rwwg_page_class #(.PAGE_W(PAGE_W), .RWW_PAGES(RWW_PAGES), .BOOT_PAGE(BOOT_PAGE))
        u_fetch_cls (.page(fetch_addr[ADDR_W-1:WORD_BITS]), .cls(fetch_cls));

    rwwg_page_class #(.PAGE_W(PAGE_W), .RWW_PAGES(RWW_PAGES), .BOOT_PAGE(BOOT_PAGE))
        u_op_cls (.page(op_page), .cls(op_cls));

    rwwg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_cls     (op_cls),
        .op_done    (op_done),
        .reread_en  (reread_en),
        .boot_lock  (boot_lock),
        .rww_blocked(rww_blocked),
        .halt       (halt),
        .reject     (op_reject)
    );

    rwwg_fetch_gate #(.DATA_W(DATA_W), .FILL_WORD(FILL_WORD)) u_gate (
        .fetch_valid(fetch_valid),
        .fetch_cls  (fetch_cls),
        .flash_rdata(flash_rdata),
        .rww_blocked(rww_blocked),
        .halt       (halt),
        .grant      (fetch_grant),
        .rdata      (fetch_rdata),
        .violation  (access_violation)
    );

    assign cpu_halt  = halt;
    assign sect_busy = rww_blocked;
endmodule

// File: rtl/rwwg_chk.sv
module rwwg_chk #(
    parameter int                ADDR_W    = 14,
    parameter int                WORD_BITS = 6,
    parameter int                DATA_W    = 16,
    parameter int                RWW_PAGES = 224,
    parameter int                BOOT_PAGE = 240,
    parameter logic [DATA_W-1:0] FILL_WORD = 16'hFFFF
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        fetch_valid,
    input logic [ADDR_W-1:0]           fetch_addr,
    input logic                        op_start,
    input logic [ADDR_W-WORD_BITS-1:0] op_page,
    input logic                        op_done,
    input logic                        reread_en,
    input logic                        boot_lock,
    input logic                        fetch_grant,
    input logic [DATA_W-1:0]           fetch_rdata,
    input logic                        access_violation,
    input logic                        cpu_halt,
    input logic                        sect_busy,
    input logic                        op_reject
);
    localparam int PW = ADDR_W - WORD_BITS;
    logic fpage_rww, opage_boot;
    assign fpage_rww  = ({1'b0, fetch_addr[ADDR_W-1:WORD_BITS]} < (PW+1)'(RWW_PAGES));
    assign opage_boot = ({1'b0, op_page} >= (PW+1)'(BOOT_PAGE));

    // R1
    rww_fetch_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_busy && fetch_valid && fpage_rww) |-> (!fetch_grant && access_violation));

    // R2
    halt_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && fetch_valid) |-> !fetch_grant);

    // R2
    halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && !op_done) |=> cpu_halt);

    // R4
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sect_busy) |-> $past(reread_en));

    // R6
    boot_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && boot_lock && opage_boot && !cpu_halt && !sect_busy)
            |=> (!cpu_halt && !sect_busy));

    // R9
    filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_grant |-> (fetch_rdata == FILL_WORD));

    // R7
    busy_start_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && (cpu_halt || sect_busy)) |-> op_reject);
endmodule

bind rwwg_top rwwg_chk #(
    .ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS), .DATA_W(DATA_W),
    .RWW_PAGES(RWW_PAGES), .BOOT_PAGE(BOOT_PAGE), .FILL_WORD(FILL_WORD)
) i_rwwg_chk (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .op_start(op_start), .op_page(op_page), .op_done(op_done), .reread_en(reread_en),
    .boot_lock(boot_lock), .fetch_grant(fetch_grant), .fetch_rdata(fetch_rdata),
    .access_violation(access_violation), .cpu_halt(cpu_halt), .sect_busy(sect_busy),
    .op_reject(op_reject)
);

// File: tb/test_rwwg_top.sv
module test_rwwg_top;
    localparam int ADDR_W = 14, WORD_BITS = 6, DATA_W = 16;
    localparam int RWW_PAGES = 224, BOOT_PAGE = 240;
    localparam logic [DATA_W-1:0] FILL = 16'hFFFF;
    localparam int PAGE_W = ADDR_W - WORD_BITS;

    logic clk = 0, rst_n = 0;
    logic fetch_valid = 0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic [DATA_W-1:0] flash_rdata = 16'h1234;
    logic op_start = 0, op_done = 0, reread_en = 0, boot_lock = 0;
    logic [PAGE_W-1:0] op_page = '0;
    logic fetch_grant, access_violation, cpu_halt, sect_busy, op_reject;
    logic [DATA_W-1:0] fetch_rdata;

    int n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    rwwg_top i_rwwg_top (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .flash_rdata(flash_rdata), .op_start(op_start), .op_page(op_page),
        .op_done(op_done), .reread_en(reread_en), .boot_lock(boot_lock),
        .fetch_grant(fetch_grant), .fetch_rdata(fetch_rdata),
        .access_violation(access_violation), .cpu_halt(cpu_halt),
        .sect_busy(sect_busy), .op_reject(op_reject)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // drive a fetch to a page and settle
    task automatic fetch_page(input int pg, input logic [DATA_W-1:0] d);
        fetch_valid = 1;
        fetch_addr  = ADDR_W'((pg << WORD_BITS) + 5);
        flash_rdata = d;
        #1;
    endtask

    task automatic start_op(input int pg);
        op_page  = PAGE_W'(pg);
        op_start = 1;
        step();
        op_start = 0;
        #1;
    endtask

    task automatic t_reset();
        chk("R8 halt after reset", cpu_halt, 0);
        chk("R8 busy after reset", sect_busy, 0);
        fetch_page(10, 16'hA5A5);
        chk("R8 grant idle rww", fetch_grant, 1);
        chk("R8 data idle", fetch_rdata, 16'hA5A5);
        fetch_valid = 0; #1;
        chk("R9 no grant idle", fetch_grant, 0);
        chk("R9 no violation", access_violation, 0);
        chk("R9 filler", fetch_rdata, FILL);
    endtask

    task automatic t_rww_op();
        start_op(3);
        chk("R3 busy set", sect_busy, 1);
        chk("R2 no halt for rww op", cpu_halt, 0);
        fetch_page(3, 16'h1111);
        chk("R1 rww blocked", fetch_grant, 0);
        chk("R1 violation", access_violation, 1);
        chk("R1 filler", fetch_rdata, FILL);
        fetch_page(RWW_PAGES - 1, 16'h2222);
        chk("R1 last rww page blocked", fetch_grant, 0);
        fetch_page(RWW_PAGES, 16'h3333);
        chk("R1 first protected page granted", fetch_grant, 1);
        chk("R1 protected data", fetch_rdata, 16'h3333);
        reread_en = 1; step(); reread_en = 0; #1;
        chk("R5 reread ignored in run", sect_busy, 1);
        op_start = 1; op_page = PAGE_W'(230); #1;
        chk("R7 start while busy refused", op_reject, 1);
        step(); op_start = 0; #1;
        chk("R7 no halt after refused", cpu_halt, 0);
        op_done = 1; step(); op_done = 0; #1;
        chk("R4 sticky after done", sect_busy, 1);
        fetch_page(3, 16'h4444);
        chk("R4 still blocked", fetch_grant, 0);
        step(); step();
        chk("R4 still busy later", sect_busy, 1);
        reread_en = 1; step(); reread_en = 0; #1;
        chk("R4 cleared after reread", sect_busy, 0);
        chk("R4 rww granted again", fetch_grant, 1);
        fetch_valid = 0; #1;
    endtask

    task automatic t_same_cycle();
        start_op(0);
        op_done = 1; reread_en = 1; step(); op_done = 0; reread_en = 0; #1;
        chk("R5 reread with done ignored", sect_busy, 1);
        fetch_page(0, 16'h5555);
        chk("R5 still blocked", fetch_grant, 0);
        reread_en = 1; step(); reread_en = 0; #1;
        chk("R4 release", sect_busy, 0);
        fetch_valid = 0; #1;
    endtask

    task automatic t_nrww_op();
        start_op(230);
        chk("R2 halt raised", cpu_halt, 1);
        chk("R2 no busy", sect_busy, 0);
        fetch_page(230, 16'h6666);
        chk("R2 protected fetch blocked", fetch_grant, 0);
        fetch_page(5, 16'h6666);
        chk("R2 rww fetch blocked", access_violation, 1);
        step();
        chk("R2 halt holds", cpu_halt, 1);
        op_done = 1; #1;
        chk("R2 halt in done cycle", cpu_halt, 1);
        step(); op_done = 0; #1;
        chk("R2 halt released", cpu_halt, 0);
        chk("R8 grant after nrww", fetch_grant, 1);
        fetch_valid = 0; #1;
    endtask

    task automatic t_boot_lock();
        boot_lock = 1;
        op_page = PAGE_W'(BOOT_PAGE); op_start = 1; #1;
        chk("R6 reject boot", op_reject, 1);
        step(); op_start = 0; #1;
        chk("R6 no halt", cpu_halt, 0);
        chk("R6 no busy", sect_busy, 0);
        op_page = PAGE_W'(BOOT_PAGE - 1); op_start = 1; #1;
        chk("R6 below boot accepted", op_reject, 0);
        step(); op_start = 0; #1;
        chk("R6 below boot halts", cpu_halt, 1);
        op_done = 1; step(); op_done = 0; #1;
        boot_lock = 0;
        start_op(255);
        chk("R6 unlocked boot op runs", cpu_halt, 1);
        op_done = 1; step(); op_done = 0; #1;
        chk("R2 back idle", cpu_halt, 0);
    endtask

    initial begin
        fork
            begin
                #100000;
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected finish");
            end
            begin
                #12 rst_n = 1;
                @(negedge clk); #1;
                t_reset();
                t_rww_op();
                t_same_cycle();
                t_nrww_op();
                t_boot_lock();
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule